// File: doc/BRIEF.md
# Paced Two-Channel Converter Sample Feeder

This block sets the rate at which samples reach a two-channel digital-to-analog converter. A DMA engine pushes 16-bit words into a small sample queue. An interval timer counts controller clock cycles up to a programmable target and fires a one-cycle trigger each time it reaches that target. Each trigger takes one word from the queue and loads it into the channel output registers. The output update rate is therefore the controller clock rate divided by the interval target.

There are two channel modes. In the paired mode, one word updates both channels: the low byte goes to channel 0 and the high byte goes to channel 1. In the alternating mode, each trigger sends the low byte of one word to a single channel. A channel pointer then moves between channel 0 and channel 1. A digital-control select decides what the converter pins carry: either the paced values or the direct values set by software.

Two single-cycle clear inputs act independently. The queue clear empties the queue and leaves the configuration unchanged. The sequencer clear restarts the timer, returns the channel pointer to channel 0 and clears the sticky underflow flag.

Top module: `dac_pacer`

## Requirements
- R1: After reset, `tick` and `underflow` are 0, `wr_ready` is 1, and with `dig_en`=1 both `dac0` and `dac1` read 0x00.
- R2: While `timer_en` is 1, `tick` pulses high for one cycle every `interval` cycles. An `interval` of 0 or 1 makes `tick` high on every cycle.
- R3: While `timer_en` is 0, `tick` stays 0 and the interval count returns to zero.
- R4: With `alt_mode`=0, a trigger pops one word and, one cycle after `tick` is high, loads bits [7:0] into channel 0 and bits [15:8] into channel 1.
- R5: With `alt_mode`=1, a trigger pops one word and loads bits [7:0] into the channel that the pointer selects. The other channel holds its value, and the pointer toggles (0 to 1, 1 to 0). The pointer is 0 after reset.
- R6: A trigger that finds the queue empty leaves both channel values unchanged and sets `underflow`. The flag stays at 1.
- R7: A one-cycle `fifo_clr` empties the queue by the next cycle, so `wr_ready` is 1 and the next trigger underflows. Mode and interval inputs are not affected.
- R8: A one-cycle `seq_clr` restarts the interval count, puts the channel pointer back to 0 and clears `underflow`. It keeps the words already in the queue.
- R9: `dig_en`=0 puts `direct0` and `direct1` on `dac0` and `dac1`. `dig_en`=1 puts the paced channel values there.
- R10: `wr_ready` is 0 when the queue holds DEPTH words. A write is taken only when `wr_valid` and `wr_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (already divided) |
| rst_n | input | 1 | Asynchronous active-low reset |
| dig_en | input | 1 | Selects paced values for the converter pins |
| timer_en | input | 1 | Enables trigger generation |
| alt_mode | input | 1 | 1: alternate channels, 0: update both |
| interval | input | 16 | Trigger interval in cycles |
| fifo_clr | input | 1 | Single-cycle queue clear |
| seq_clr | input | 1 | Single-cycle timer and sequencer clear |
| wr_valid | input | 1 | Sample word offered by the DMA side |
| wr_data | input | 16 | Sample word |
| wr_ready | output | 1 | Queue can take a word |
| direct0 | input | 8 | Software value for channel 0 |
| direct1 | input | 8 | Software value for channel 1 |
| dac0 | output | 8 | Channel 0 converter code |
| dac1 | output | 8 | Channel 1 converter code |
| tick | output | 1 | Trigger pulse |
| underflow | output | 1 | Sticky empty-on-trigger flag |

## Verification
The assertions check on every cycle that a disabled timer gives no trigger and that a sequencer clear leaves the pointer at zero with the flag low. They also check that the queue count never exceeds its depth, that a queue clear empties it, that an empty trigger raises the flag, and that an alternating update never changes both channels together. Only the bench scenarios can show the exact spacing between triggers for a given interval, the byte routing for specific words, the pointer sequence across mixed modes, and that queued words survive a sequencer clear.

// File: rtl/dac_pacer_pkg.sv
package dac_pacer_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 8;

  typedef logic [CODE_W-1:0]   code_t;
  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_sel_e;
endpackage

// File: rtl/dacp_interval_timer.sv
module dacp_interval_timer #(
  parameter int TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [TGT_W-1:0] target,
  output logic             tick
);
  logic [TGT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             wrap;

  assign wrap = ({1'b0, cnt_q} + {{TGT_W{1'b0}}, 1'b1}) >= {1'b0, target};

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!run || restart) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R3
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick_q);

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0) && !tick_q);
endmodule

// File: rtl/dacp_sample_fifo.sv
module dacp_sample_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == DEPTH_C);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign pop_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/dacp_chan_seq.sv
module dacp_chan_seq
  import dac_pacer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    trig,
  input  logic    alt,
  input  logic    clr,
  input  logic    q_empty,
  input  sample_t q_data,
  output logic    q_pop,
  output code_t   ch0,
  output code_t   ch1,
  output logic    uflow
);
  code_t     ch0_q, ch0_d, ch1_q, ch1_d;
  chan_sel_e ptr_q, ptr_d;
  logic      uf_q, uf_d;
  logic      upd, ld0, ld1;

  assign upd   = trig && !q_empty;
  assign q_pop = upd;
  assign ld0   = upd && (!alt || ptr_q == CH_A);
  assign ld1   = upd && (!alt || ptr_q == CH_B);

  always_comb begin
    ch0_d = ld0 ? q_data[7:0] : ch0_q;
    ch1_d = ld1 ? (alt ? q_data[7:0] : q_data[15:8]) : ch1_q;
    ptr_d = ptr_q;
    if (clr) begin
      ptr_d = CH_A;
    end else if (upd && alt) begin
      ptr_d = (ptr_q == CH_A) ? CH_B : CH_A;
    end
    uf_d = uf_q;
    if (clr) begin
      uf_d = 1'b0;
    end else if (trig && q_empty) begin
      uf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch0_q <= '0;
      ch1_q <= '0;
      ptr_q <= CH_A;
      uf_q  <= 1'b0;
    end else begin
      if (ld0) ch0_q <= ch0_d;
      if (ld1) ch1_q <= ch1_d;
      ptr_q <= ptr_d;
      uf_q  <= uf_d;
    end
  end

  assign ch0   = ch0_q;
  assign ch1   = ch1_q;
  assign uflow = uf_q;

  // R6
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && q_empty && !clr) |=> uf_q);

  // R5
  alt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt |=> ($stable(ch0_q) || $stable(ch1_q)));

  // R8
  clr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == CH_A) && !uf_q);
endmodule

// File: rtl/dac_pacer.sv
module dac_pacer
  import dac_pacer_pkg::*;
#(
  parameter int TGT_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dig_en,
  input  logic             timer_en,
  input  logic             alt_mode,
  input  logic [TGT_W-1:0] interval,
  input  logic             fifo_clr,
  input  logic             seq_clr,
  input  logic             wr_valid,
  input  logic [15:0]      wr_data,
  output logic             wr_ready,
  input  logic [7:0]       direct0,
  input  logic [7:0]       direct1,
  output logic [7:0]       dac0,
  output logic [7:0]       dac1,
  output logic             tick,
  output logic             underflow
);
  logic    trig, q_empty, q_full, q_pop;
  sample_t q_data;
  code_t   ch0, ch1;

  dacp_interval_timer #(.TGT_W(TGT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timer_en),
    .restart (seq_clr),
    .target  (interval),
    .tick    (trig)
  );

  dacp_sample_fifo #(.DATA_W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (fifo_clr),
    .push      (wr_valid),
    .push_data (wr_data),
    .pop       (q_pop),
    .pop_data  (q_data),
    .empty     (q_empty),
    .full      (q_full)
  );

  dacp_chan_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .alt     (alt_mode),
    .clr     (seq_clr),
    .q_empty (q_empty),
    .q_data  (q_data),
    .q_pop   (q_pop),
    .ch0     (ch0),
    .ch1     (ch1),
    .uflow   (underflow)
  );

  assign wr_ready = !q_full;
  assign tick     = trig;
  assign dac0     = dig_en ? ch0 : direct0;
  assign dac1     = dig_en ? ch1 : direct1;
endmodule

// File: tb/sim_dac_pacer.sv
module sim_dac_pacer;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dig_en = 1'b1, timer_en = 1'b0, alt_mode = 1'b0;
  logic [15:0] interval = 16'd2;
  logic        fifo_clr = 1'b0, seq_clr = 1'b0, wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  direct0 = '0, direct1 = '0;
  logic        wr_ready, tick, underflow;
  logic [7:0]  dac0, dac1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dac_pacer #(.TGT_W(16), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .dig_en(dig_en), .timer_en(timer_en),
    .alt_mode(alt_mode), .interval(interval), .fifo_clr(fifo_clr),
    .seq_clr(seq_clr), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .direct0(direct0), .direct1(direct1),
    .dac0(dac0), .dac1(dac1), .tick(tick), .underflow(underflow)
  );

  // {alt, word, expected dac0, expected dac1}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 16'hA55A, 8'h5A, 8'hA5},   // R4
    {1'b0, 16'h1234, 8'h34, 8'h12},   // R4
    {1'b1, 16'h00C3, 8'hC3, 8'h12},   // R5 pointer 0
    {1'b1, 16'h0077, 8'hC3, 8'h77},   // R5 pointer 1
    {1'b1, 16'h0011, 8'h11, 8'h77},   // R5 pointer 0
    {1'b0, 16'hBEEF, 8'hEF, 8'hBE}    // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_seq();
    @(negedge clk); seq_clr = 1'b1;
    @(negedge clk); seq_clr = 1'b0;
  endtask

  // enable timer, wait for trigger, sample the cycle after, disable
  task automatic fire(output logic seen);
    seen = 1'b0;
    @(negedge clk);
    interval = 16'd2;
    timer_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tick) begin seen = 1'b1; break; end
    end
    @(negedge clk);
    timer_en = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic seen;
    int   t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 tick", tick, 0);
    check("R1 underflow", underflow, 0);
    check("R1 wr_ready", wr_ready, 1);
    check("R1 dac0", dac0, 0);
    check("R1 dac1", dac1, 0);

    // R9
    dig_en = 1'b0; direct0 = 8'h3C; direct1 = 8'hC3;
    #1;
    check("R9 direct dac0", dac0, 8'h3C);
    check("R9 direct dac1", dac1, 8'hC3);
    dig_en = 1'b1;
    #1;
    check("R9 paced dac0", dac0, 8'h00);

    // R4 / R5 table walk
    for (int v = 0; v < 6; v++) begin
      alt_mode = VEC[v][32];
      push(VEC[v][31:16]);
      fire(seen);
      check("R4/R5 trigger", seen, 1);
      check("R4/R5 dac0", dac0, VEC[v][15:8]);
      check("R4/R5 dac1", dac1, VEC[v][7:0]);
    end
    alt_mode = 1'b0;
    check("R6 no underflow yet", underflow, 0);

    // R3
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick) seen = 1'b1;
    end
    check("R3 no tick while disabled", seen, 0);

    // R2 interval 5
    interval = 16'd5;
    timer_en = 1'b1;
    t0 = -1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tick) begin
        if (t0 < 0) t0 = cyc;
        else begin check("R2 spacing 5", cyc - t0, 5); break; end
      end
    end
    // R2 interval 0
    interval = 16'd0;
    @(negedge clk); @(negedge clk);
    check("R2 interval 0 tick", tick, 1);
    @(negedge clk);
    check("R2 interval 0 next tick", tick, 1);
    timer_en = 1'b0;
    @(negedge clk);
    // R6
    check("R6 underflow sticky", underflow, 1);
    check("R6 dac0 held", dac0, 8'hEF);
    check("R6 dac1 held", dac1, 8'hBE);

    // R8 pointer and flag
    alt_mode = 1'b1;
    push(16'h0099);          // pointer 1 -> channel 1
    fire(seen);
    check("R8 pre dac1", dac1, 8'h99);
    pulse_seq();
    check("R8 underflow cleared", underflow, 0);
    push(16'h0055);
    fire(seen);
    check("R8 pointer back to ch0", dac0, 8'h55);
    check("R8 ch1 held", dac1, 8'h99);
    alt_mode = 1'b0;

    // R10
    for (int i = 0; i < DEPTH; i++) push(16'h0100 + 16'(i));
    check("R10 full not ready", wr_ready, 0);
    push(16'hFFFF);
    check("R10 still full", wr_ready, 0);

    // R8 keeps queue contents
    pulse_seq();
    fire(seen);
    check("R8 queue kept dac0", dac0, 8'h00);
    check("R8 queue kept dac1", dac1, 8'h01);
    check("R10 ready after pop", wr_ready, 1);

    // R7
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
    check("R7 ready after clear", wr_ready, 1);
    check("R7 flag before", underflow, 0);
    fire(seen);
    check("R7 underflow after clear", underflow, 1);
    check("R7 dac0 held", dac0, 8'h00);
    check("R7 dac1 held", dac1, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule